// File: doc/BRIEF.md
# Dual Serial Audio Output Generator

This block drives two clock-master serial audio output ports from one master clock of nominally 24.576 MHz; the block's `clk` is that master clock. The first port is mono-framed and runs at 384 kHz frames. It has two data lines: the left channel goes out on one line and the right channel on the other, as one 32-bit word per frame. The second port is a stereo I2S port with 32-bit slots. A rate code sets its frame rate to 48, 96 or 192 kHz. Every bit clock and frame sync is made by counting master-clock cycles, so each rate is an exact multiple of 48 kHz.

Each port takes its samples over its own valid/ready stream carrying a 24-bit left and right pair in two's complement. Each stream has a one-entry holding slot. Ready is high exactly when that slot is empty, and a sample is accepted on a clock edge where valid and ready are both high. A producer that sees ready low must keep valid and its data steady until ready returns. The holding slot is emptied at the port's next frame start. If no new sample is waiting then, the port sends its previous sample again.

The lock, soft-mute, phase-inversion, justification and rate inputs are plain level controls. The formatting controls and the rate code are sampled only at a frame start, so a frame is never sent half in one setting and half in another. While lock is low every output pin is held low.

Top module: `audtx_dual_ser_out`

## Requirements
- R1: The mono-framed port's bit clock has a period of 2 master-clock cycles, low in the first cycle and high in the second. A frame is 32 bits, which is 64 cycles. Its frame sync is high during bits 0 to 15 of each frame and low during bits 16 to 31.
- R2: On the mono-framed port, line `mf_dl` carries the left slot and `mf_dr` carries the right slot. Each slot is sent MSB first, starting at bit 0 of the frame, and each bit changes at the start of its bit period while the bit clock is low.
- R3: With `rjust`=0 a mono-framed slot holds the sample in bits 31:8 and zeros in bits 7:0. With `rjust`=1 it holds the sample in bits 23:0, and bits 31:24 are copies of the sample's sign bit. The setting is sampled at the frame start.
- R4: The stereo port sends 64 bits per frame. Word select `st_ws` is low during bits 0 to 31 (left slot) and high during bits 32 to 63 (right slot). Each slot's MSB goes out one bit after word select changes. Bit 0 of a frame repeats the last bit of the previous frame. Each stereo slot holds the 24-bit sample in its upper bits, with zeros in the lower 8.
- R5: The stereo rate code gives the master-clock cycles per bit as follows: 01 gives 8 (512 cycles per frame, 48 kHz), 10 gives 4 (96 kHz), 11 gives 2 (192 kHz), and the reserved code 00 gives 8. The bit clock is low for the first half of each bit period. A new code is taken only at a frame start.
- R6: While reset is asserted, or while lock is low, all seven output pins are low. After lock has been seen high on a clock edge, both ports begin a new frame at bit 0 on the following cycle.
- R7: With soft mute set at a frame start, both slots of that frame are all zeros, and both bit clocks and frame syncs keep running.
- R8: With inversion set at a frame start, each slot carries the negated sample. The value -8388608 becomes +8388607.
- R9: Each stream's ready is high exactly when its holding slot is empty. An accepted sample is used from the port's next frame start on. If no sample is waiting at a frame start, the previous one repeats. After reset the previous sample is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock | input | 1 | Input lock status; low forces hard mute |
| soft_mute | input | 1 | Send zero samples, clocks keep running |
| invert | input | 1 | Negate every sample (saturating) |
| rjust | input | 1 | Mono-framed justification: 0 left, 1 right |
| rate_sel | input | 2 | Stereo frame rate code |
| hs_valid | input | 1 | Mono-framed stream sample valid |
| hs_ready | output | 1 | Mono-framed stream holding slot empty |
| hs_left | input | 24 | Mono-framed stream left sample |
| hs_right | input | 24 | Mono-framed stream right sample |
| ls_valid | input | 1 | Stereo stream sample valid |
| ls_ready | output | 1 | Stereo stream holding slot empty |
| ls_left | input | 24 | Stereo stream left sample |
| ls_right | input | 24 | Stereo stream right sample |
| mf_fsync | output | 1 | Mono-framed frame sync |
| mf_bclk | output | 1 | Mono-framed bit clock |
| mf_dl | output | 1 | Mono-framed left data line |
| mf_dr | output | 1 | Mono-framed right data line |
| st_ws | output | 1 | Stereo word select |
| st_bclk | output | 1 | Stereo bit clock |
| st_sd | output | 1 | Stereo serial data |

## Verification
The assertions check these properties on every cycle:
- every pin is low in the cycle after lock was seen low;
- the mono bit clock never stays high for two cycles;
- the bit-period counter stays within its divider;
- the divider and the loaded words do not change inside a frame;
- a full holding slot is neither overwritten nor lost.

Other behaviour only shows in the bench's scenarios:
- the bit order on the data lines;
- left and right justification and sign extension;
- saturation of the most negative sample;
- the one-bit I2S delay;
- the frame periods for each rate code, including the reserved code;
- the repeat of a sample when the stream runs dry;
- restart after lock returns.

// File: rtl/audtx_pkg.sv
package audtx_pkg;
  typedef enum logic [1:0] {
    RATE_RSV = 2'b00,
    RATE_1X  = 2'b01,
    RATE_2X  = 2'b10,
    RATE_4X  = 2'b11
  } rate_e;

  typedef enum logic {
    JUST_LEFT  = 1'b0,
    JUST_RIGHT = 1'b1
  } just_e;
endpackage

// File: rtl/audtx_slot_fmt.sv
module audtx_slot_fmt #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                inv,
  input  logic                mute,
  input  logic                rjust,
  output logic [SLOT_W-1:0]   slot
);
  localparam int PAD_W = SLOT_W - SAMPLE_W;
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] negated;
  logic [SAMPLE_W-1:0] val;

  // negation saturates: the most negative code maps to the most positive
  assign negated = (sample == MOST_NEG) ? ~MOST_NEG : (~sample + 1'b1);

  always_comb begin
    if (mute)     val = '0;
    else if (inv) val = negated;
    else          val = sample;
  end

  assign slot = rjust ? {{PAD_W{val[SAMPLE_W-1]}}, val} : {val, {PAD_W{1'b0}}};
endmodule

// File: rtl/audtx_hold.sv
module audtx_hold #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  input  logic                take,
  output logic [SAMPLE_W-1:0] nxt_l,
  output logic [SAMPLE_W-1:0] nxt_r
);
  logic                hold_v;
  logic [SAMPLE_W-1:0] hold_l, hold_r, last_l, last_r;

  assign in_ready = !hold_v;
  assign nxt_l    = hold_v ? hold_l : last_l;
  assign nxt_r    = hold_v ? hold_r : last_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      last_l <= '0;
      last_r <= '0;
    end else begin
      if (take) begin
        last_l <= nxt_l;
        last_r <= nxt_r;
      end
      if (in_valid && !hold_v) begin
        hold_v <= 1'b1;
        hold_l <= in_l;
        hold_r <= in_r;
      end else if (take) begin
        hold_v <= 1'b0;
      end
    end
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && !take |=> hold_v && $stable(hold_l) && $stable(hold_r)); // R9
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R9
endmodule

// File: rtl/audtx_ser.sv
module audtx_ser #(
  parameter int FRAME_W = 32,
  parameter int LINES   = 2,
  parameter bit I2S     = 1'b0,
  parameter int DIV_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lock,
  input  logic [DIV_W-1:0]         div_in,
  input  logic [LINES*FRAME_W-1:0] word_in,
  output logic                     load,
  output logic                     bclk,
  output logic                     fsync,
  output logic [LINES-1:0]         sd
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam int HALF  = FRAME_W / 2;
  // first data index of a frame; with the I2S delay it wraps so that bit k reads FRAME_W-k
  localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(FRAME_W - 1 + int'(I2S));

  logic               run;
  logic [DIV_W-1:0]   cnt, div_q;
  logic [BIT_W-1:0]   bidx, idx;
  logic [FRAME_W-1:0] word_q [LINES];
  logic [LINES-1:0]   lsb_q;
  logic               bit_end, frame_end, active;

  assign bit_end   = (cnt == div_q - 1'b1);
  assign frame_end = bit_end && (bidx == BIT_W'(FRAME_W - 1));
  assign load      = lock && (!run || frame_end);
  assign active    = run && lock;
  assign idx       = TOP_IDX - bidx;
  assign bclk      = active && (cnt >= (div_q >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      bidx  <= '0;
      div_q <= '0;
      lsb_q <= '0;
      for (int i = 0; i < LINES; i++) word_q[i] <= '0;
    end else if (!lock) begin
      run   <= 1'b0;
      cnt   <= '0;
      bidx  <= '0;
      lsb_q <= '0;
      for (int i = 0; i < LINES; i++) word_q[i] <= '0;
    end else if (load) begin
      run   <= 1'b1;
      cnt   <= '0;
      bidx  <= '0;
      div_q <= div_in;
      for (int i = 0; i < LINES; i++) begin
        lsb_q[i]  <= word_q[i][0];
        word_q[i] <= word_in[i*FRAME_W +: FRAME_W];
      end
    end else if (bit_end) begin
      cnt  <= '0;
      bidx <= bidx + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  generate
    if (I2S) begin : g_ws
      assign fsync = active && (bidx >= BIT_W'(HALF));
    end else begin : g_fs
      assign fsync = active && (bidx < BIT_W'(HALF));
    end
    for (genvar i = 0; i < LINES; i++) begin : g_line
      if (I2S) begin : g_dly
        assign sd[i] = active && ((bidx == '0) ? lsb_q[i] : word_q[i][idx]);
      end else begin : g_now
        assign sd[i] = active && word_q[i][idx];
      end
    end
  endgenerate

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < div_q); // R5
  AST_DIV_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && lock && !load |=> $stable(div_q)); // R5
  AST_WORD_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && lock && !load |=> $stable(word_q[0])); // R7
endmodule

// File: rtl/audtx_dual_ser_out.sv
module audtx_dual_ser_out #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int BASE_DIV = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock,
  input  logic                soft_mute,
  input  logic                invert,
  input  logic                rjust,
  input  logic [1:0]          rate_sel,
  input  logic                hs_valid,
  output logic                hs_ready,
  input  logic [SAMPLE_W-1:0] hs_left,
  input  logic [SAMPLE_W-1:0] hs_right,
  input  logic                ls_valid,
  output logic                ls_ready,
  input  logic [SAMPLE_W-1:0] ls_left,
  input  logic [SAMPLE_W-1:0] ls_right,
  output logic                mf_fsync,
  output logic                mf_bclk,
  output logic                mf_dl,
  output logic                mf_dr,
  output logic                st_ws,
  output logic                st_bclk,
  output logic                st_sd
);
  import audtx_pkg::*;

  localparam int DIV_W  = $clog2(BASE_DIV + 1);
  localparam int MF_DIV = BASE_DIV / 4;
  localparam int ST_W   = 2 * SLOT_W;

  rate_e            rcode;
  just_e            jmode;
  logic [DIV_W-1:0] st_div;
  logic             mf_load, st_load;
  logic [SAMPLE_W-1:0] mf_nl, mf_nr, st_nl, st_nr;
  logic [SLOT_W-1:0]   mf_slot [2];
  logic [SLOT_W-1:0]   st_slot [2];
  logic [1:0]          mf_sd;
  logic [0:0]          st_sdv;

  assign rcode = rate_e'(rate_sel);
  assign jmode = just_e'(rjust);

  always_comb begin
    case (rcode)
      RATE_2X: st_div = DIV_W'(BASE_DIV / 2);
      RATE_4X: st_div = DIV_W'(BASE_DIV / 4);
      default: st_div = DIV_W'(BASE_DIV);
    endcase
  end

  audtx_hold #(.SAMPLE_W(SAMPLE_W)) u_mf_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(hs_valid), .in_ready(hs_ready),
    .in_l(hs_left), .in_r(hs_right), .take(mf_load), .nxt_l(mf_nl), .nxt_r(mf_nr));

  audtx_hold #(.SAMPLE_W(SAMPLE_W)) u_st_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(ls_valid), .in_ready(ls_ready),
    .in_l(ls_left), .in_r(ls_right), .take(st_load), .nxt_l(st_nl), .nxt_r(st_nr));

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_fmt
      audtx_slot_fmt #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_mf_fmt (
        .sample(ch == 0 ? mf_nl : mf_nr), .inv(invert), .mute(soft_mute),
        .rjust(jmode == JUST_RIGHT), .slot(mf_slot[ch]));
      audtx_slot_fmt #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_st_fmt (
        .sample(ch == 0 ? st_nl : st_nr), .inv(invert), .mute(soft_mute),
        .rjust(1'b0), .slot(st_slot[ch]));
    end
  endgenerate

  audtx_ser #(.FRAME_W(SLOT_W), .LINES(2), .I2S(1'b0), .DIV_W(DIV_W)) u_mf_ser (
    .clk(clk), .rst_n(rst_n), .lock(lock), .div_in(DIV_W'(MF_DIV)),
    .word_in({mf_slot[1], mf_slot[0]}), .load(mf_load),
    .bclk(mf_bclk), .fsync(mf_fsync), .sd(mf_sd));

  audtx_ser #(.FRAME_W(ST_W), .LINES(1), .I2S(1'b1), .DIV_W(DIV_W)) u_st_ser (
    .clk(clk), .rst_n(rst_n), .lock(lock), .div_in(st_div),
    .word_in({st_slot[0], st_slot[1]}), .load(st_load),
    .bclk(st_bclk), .fsync(st_ws), .sd(st_sdv));

  assign mf_dl = mf_sd[0];
  assign mf_dr = mf_sd[1];
  assign st_sd = st_sdv[0];

  AST_HARD_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !(mf_fsync || mf_bclk || mf_dl || mf_dr || st_ws || st_bclk || st_sd)); // R6
  AST_MF_BCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    mf_bclk |=> !mf_bclk); // R1
endmodule

// File: tb/audtx_dual_ser_out_tb_top.sv
`timescale 1ns/1ps
module audtx_dual_ser_out_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 1'b0, soft_mute = 1'b0, invert = 1'b0, rjust = 1'b0;
  logic [1:0] rate_sel = 2'b01;
  logic hs_valid = 1'b0, ls_valid = 1'b0;
  logic [23:0] hs_left = '0, hs_right = '0, ls_left = '0, ls_right = '0;
  logic hs_ready, ls_ready;
  logic mf_fsync, mf_bclk, mf_dl, mf_dr, st_ws, st_bclk, st_sd;

  int total = 0, bad = 0;
  bit hs_auto = 1'b0;

  always #5 clk = ~clk;

  audtx_dual_ser_out dut_i (
    .clk(clk), .rst_n(rst_n), .lock(lock), .soft_mute(soft_mute), .invert(invert),
    .rjust(rjust), .rate_sel(rate_sel),
    .hs_valid(hs_valid), .hs_ready(hs_ready), .hs_left(hs_left), .hs_right(hs_right),
    .ls_valid(ls_valid), .ls_ready(ls_ready), .ls_left(ls_left), .ls_right(ls_right),
    .mf_fsync(mf_fsync), .mf_bclk(mf_bclk), .mf_dl(mf_dl), .mf_dr(mf_dr),
    .st_ws(st_ws), .st_bclk(st_bclk), .st_sd(st_sd));

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s t=%0t act=%0h exp=%0h", req, what, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic logic [31:0] ref_slot(logic [23:0] x, bit rj, bit inv, bit mute);
    int v;
    v = $signed(x);
    if (inv) v = (v == -8388608) ? 8388607 : -v;
    if (mute) v = 0;
    return rj ? 32'(v) : (32'(v) << 8);
  endfunction

  logic [47:0] hq[$], lq[$];
  logic [47:0] h_last = '0, l_last = '0, smp;
  bit m_run = 0, s_run = 0, s_lsb = 0, h_emp, l_emp;
  int m_t = 0, s_t = 0, s_div = 8;
  logic [31:0] m_wl = '0, m_wr = '0;
  logic [63:0] s_w = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq.delete(); lq.delete(); h_last = '0; l_last = '0;
      m_run = 0; s_run = 0; m_t = 0; s_t = 0; s_div = 8; s_lsb = 0;
      m_wl = '0; m_wr = '0; s_w = '0;
    end else begin
      h_emp = (hq.size() == 0);
      l_emp = (lq.size() == 0);
      if (!lock) begin
        m_run = 0; m_t = 0; m_wl = '0; m_wr = '0;
        s_run = 0; s_t = 0; s_w = '0; s_lsb = 0;
      end else begin
        if (!m_run || m_t == 63) begin
          smp = (hq.size() > 0) ? hq.pop_front() : h_last;
          h_last = smp;
          m_wl = ref_slot(smp[47:24], rjust, invert, soft_mute);
          m_wr = ref_slot(smp[23:0], rjust, invert, soft_mute);
          m_run = 1; m_t = 0;
        end else m_t++;
        if (!s_run || s_t == 64 * s_div - 1) begin
          smp = (lq.size() > 0) ? lq.pop_front() : l_last;
          l_last = smp;
          s_lsb = s_w[0];
          s_div = (rate_sel == 2'b10) ? 4 : (rate_sel == 2'b11) ? 2 : 8;
          s_w = {ref_slot(smp[47:24], 0, invert, soft_mute), ref_slot(smp[23:0], 0, invert, soft_mute)};
          s_run = 1; s_t = 0;
        end else s_t++;
      end
      if (h_emp && hs_valid) hq.push_back({hs_left, hs_right});
      if (l_emp && ls_valid) lq.push_back({ls_left, ls_right});
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    bit am, as;
    int mb, sb;
    string tm, tmd, tsc, tsd;
    am = m_run && lock; as = s_run && lock;
    mb = m_t / 2; sb = s_t / s_div;
    tm  = lock ? "R1" : "R6";
    tmd = !lock ? "R6" : (rjust ? "R3" : "R2");
    tsc = lock ? "R5" : "R6";
    tsd = lock ? "R4" : "R6";
    chk(tm,  "mf_bclk",  mf_bclk,  am && (m_t % 2 == 1));
    chk(tm,  "mf_fsync", mf_fsync, am && (mb < 16));
    chk(tmd, "mf_dl",    mf_dl,    am && m_wl[31 - mb]);
    chk(tmd, "mf_dr",    mf_dr,    am && m_wr[31 - mb]);
    chk(tsc, "st_bclk",  st_bclk,  as && ((s_t % s_div) >= s_div / 2));
    chk(tsd, "st_ws",    st_ws,    as && (sb >= 32));
    chk(tsd, "st_sd",    st_sd,    as && ((sb == 0) ? s_lsb : s_w[64 - sb]));
    chk("R9", "hs_ready", hs_ready, hq.size() == 0);
    chk("R9", "ls_ready", ls_ready, lq.size() == 0);
  end

  // ---------------- stimulus helpers ----------------
  int seed_h = 7, seed_l = 99;
  function automatic logic [23:0] nxt(inout int s);
    s = s * 1103515245 + 12345;
    return ((s & 32'h1F) == 0) ? 24'h800000 : 24'(s >>> 5);
  endfunction

  task automatic push_hs(logic [23:0] l, logic [23:0] r);
    bit rd;
    hs_valid = 1'b1; hs_left = l; hs_right = r;
    forever begin
      @(negedge clk); rd = hs_ready;
      @(posedge clk); #1;
      if (rd) break;
    end
    hs_valid = 1'b0;
  endtask

  initial begin : ls_feeder
    bit rd;
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        ls_valid = 1'b1; ls_left = nxt(seed_l); ls_right = nxt(seed_l);
        forever begin
          @(negedge clk); rd = ls_ready;
          @(posedge clk); #1;
          if (rd) break;
        end
        ls_valid = 1'b0;
        repeat (seed_l[3:0] * 40) @(posedge clk);
      end
    end
  end

  initial begin : hs_feeder
    forever begin
      @(posedge clk); #1;
      if (hs_auto) begin
        push_hs(nxt(seed_h), nxt(seed_h));
        repeat (seed_h[2:0] * 12) @(posedge clk);
        #1;
      end
    end
  end

  task automatic grab_mono(output logic [31:0] wl, output logic [31:0] wr);
    bit pf = 1'b1;
    int n = 0;
    forever begin
      @(negedge clk);
      if (mf_fsync && !pf) break;
      pf = mf_fsync;
    end
    wl = '0; wr = '0;
    while (n < 32) begin
      if (mf_bclk) begin wl = {wl[30:0], mf_dl}; wr = {wr[30:0], mf_dr}; n++; end
      if (n < 32) @(negedge clk);
    end
  endtask

  task automatic ws_period(output int p);
    bit pf = 1'b1;
    p = 0;
    forever begin @(negedge clk); if (st_ws && !pf) break; pf = st_ws; end
    pf = 1'b1;
    forever begin @(negedge clk); p++; if (st_ws && !pf) break; pf = st_ws; end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1..R9 watchdog expired act=running exp=finished");
    summary();
  end

  initial begin : main
    logic [31:0] wl, wr;
    int p;
    // reset state
    repeat (3) @(negedge clk);
    chk("R6", "pins in reset", {mf_fsync, mf_bclk, mf_dl, mf_dr, st_ws, st_bclk, st_sd}, 0);
    chk("R9", "hs_ready in reset", hs_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (20) @(posedge clk);
    #1 lock = 1'b1;
    // R9: no sample sent yet, previous sample is zero
    grab_mono(wl, wr);
    chk("R9", "initial repeat zero", {wl, wr}, 64'h0);
    // R2/R3: left-justified, distinct channels
    push_hs(24'h000001, 24'h000002);
    push_hs(24'h123456, 24'hABCDEF);
    grab_mono(wl, wr);
    chk("R3", "lj left slot", wl, 32'h12345600);
    chk("R2", "right line slot", wr, 32'hABCDEF00);
    // R9: stream runs dry, same sample repeats
    grab_mono(wl, wr);
    chk("R9", "repeat last sample", wl, 32'h12345600);
    // R3: right-justified with sign extension
    rjust = 1'b1;
    push_hs(24'h000003, 24'h000004);
    push_hs(24'h876543, 24'h012345);
    grab_mono(wl, wr);
    chk("R3", "rj negative", wl, 32'hFF876543);
    chk("R3", "rj positive", wr, 32'h00012345);
    // R8: inversion with saturation
    invert = 1'b1;
    push_hs(24'h000005, 24'h000006);
    push_hs(24'h800000, 24'hFFFFFF);
    grab_mono(wl, wr);
    chk("R8", "saturated negate", wl, 32'h007FFFFF);
    chk("R8", "negate minus one", wr, 32'h00000001);
    invert = 1'b0; rjust = 1'b0;
    // R7: soft mute, clocks keep running
    soft_mute = 1'b1;
    push_hs(24'h000007, 24'h000008);
    push_hs(24'h7FFFFF, 24'h555555);
    grab_mono(wl, wr);
    chk("R7", "soft mute zero data", {wl, wr}, 64'h0);
    ws_period(p);
    chk("R7", "stereo clocks under mute", p, 512);
    soft_mute = 1'b0;
    // background traffic, rate changes mid-frame
    hs_auto = 1'b1;
    ws_period(p); chk("R5", "period code 01", p, 512);
    rate_sel = 2'b10;
    ws_period(p); ws_period(p); chk("R5", "period code 10", p, 256);
    invert = 1'b1; rjust = 1'b1;
    rate_sel = 2'b11;
    ws_period(p); ws_period(p); chk("R5", "period code 11", p, 128);
    invert = 1'b0;
    rate_sel = 2'b00;
    ws_period(p); ws_period(p); chk("R5", "period reserved 00", p, 512);
    rjust = 1'b0;
    // R6: lock drop mid-frame, then relock
    repeat (137) @(posedge clk);
    #1 lock = 1'b0;
    @(negedge clk);
    chk("R6", "pins after unlock", {mf_fsync, mf_bclk, mf_dl, mf_dr, st_ws, st_bclk, st_sd}, 0);
    repeat (50) @(posedge clk);
    #1 lock = 1'b1;
    @(negedge clk);
    chk("R6", "first locked cycle still low", {mf_fsync, mf_bclk, st_ws, st_bclk}, 0);
    @(negedge clk);
    chk("R6", "frame start after lock", {mf_fsync, st_ws}, 2'b10);
    rate_sel = 2'b01;
    repeat (3000) @(posedge clk);
    hs_auto = 1'b0;
    repeat (200) @(posedge clk);
    summary();
  end
endmodule